// File: doc/BRIEF.md
# Multi-size Shift and Rotate Unit

This unit performs eight shift and rotate operations on a byte, word or long register operand. Each operation moves the operand one or two places. It writes back a full register image and registers the condition flags N, Z, V and C. The active width comes from the size select. Only those low bits are shifted. The register bits above the active width come back unchanged, so the result can be written straight into the source register.

The unit builds every two-place operation from two one-place steps, and the carry out of the first step feeds the second. A through-carry rotate therefore chains the incoming C across both places. The arithmetic left shift collects overflow from both steps. The unit has one register stage. A request presented with `valid_i` high appears on the outputs one clock later. Outputs hold their values while no request is presented.

Top module: `srot_unit`

## Requirements
- R1: `size_i` selects the active width: 0 = byte (bits 7:0), 1 = word (bits 15:0), 2 or 3 = long (bits 31:0). Only the active bits are shifted, and bits of `result_o` above the active width equal the corresponding operand bits.
- R2: `two_i` = 0 moves one place and `two_i` = 1 moves two places. A two-place result, C and V equal two successive one-place steps, with the first step's C used as the second step's incoming carry.
- R3: Logical shifts (`op_i` 0 = left, 1 = right) fill the vacated bit with 0, put the last bit moved out into C, and clear V.
- R4: Arithmetic left shift (`op_i` 2) fills with 0 and puts the last bit moved out into C. V is 1 when the top two active bits differ (one place), or when the top three active bits are not all equal (two places).
- R5: Arithmetic right shift (`op_i` 3) keeps the active MSB in place, puts the last bit moved out into C, and clears V.
- R6: Plain rotates (`op_i` 4 = left, 5 = right) feed the bit leaving one end into the other end and into C, and clear V.
- R7: Rotates through carry (`op_i` 6 = left, 7 = right) shift the incoming `carry_i` into the vacated end and move the bit leaving into C. V is cleared.
- R8: N equals the MSB of the active result bits. Z is 1 exactly when all active result bits are 0.
- R9: Result and flags update on the clock edge after `valid_i` is sampled high, and `valid_o` is high for that cycle only. With `valid_i` low, `valid_o` is low and the outputs keep their values. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request strobe |
| operand_i | input | 32 | Source register value |
| size_i | input | 2 | Operand size select |
| op_i | input | 3 | Operation select |
| two_i | input | 1 | 1 = move two places, 0 = one place |
| carry_i | input | 1 | Incoming C flag |
| valid_o | output | 1 | Result valid |
| result_o | output | 32 | Register image to write back |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | Carry flag |

## Verification
Assertions check several things on every cycle. Upper register bits are preserved, and Z agrees with the active result bits. V stays clear for every operation except arithmetic left. Arithmetic right keeps the sign. Plain rotates conserve the number of ones, and through-carry rotates conserve the ones counted over operand plus C. Two behaviours need the bench scenarios, because no single-cycle property expresses them: the exact bit positions, and the carry chained between the two steps of a two-place move. The bench checks these against a behavioural model across all sizes, operations, amounts and carry inputs. The patterns include 0x80, 0x40 and the matching word and long edge values.

// File: rtl/srot_pkg.sv
package srot_pkg;

  typedef enum logic [2:0] {
    OP_SHLL  = 3'd0,
    OP_SHLR  = 3'd1,
    OP_SHAL  = 3'd2,
    OP_SHAR  = 3'd3,
    OP_ROTL  = 3'd4,
    OP_ROTR  = 3'd5,
    OP_ROTXL = 3'd6,
    OP_ROTXR = 3'd7
  } srot_op_e;

  // Lane index for a size code; codes past the last lane map to the widest.
  function automatic int unsigned lane_sel(logic [1:0] sz, int unsigned lanes);
    int unsigned s;
    s = int'(sz);
    return (s >= lanes) ? lanes - 1 : s;
  endfunction

  function automatic int unsigned lane_width(logic [1:0] sz, int unsigned data_w,
                                             int unsigned lanes);
    return data_w >> (lanes - 1 - lane_sel(sz, lanes));
  endfunction

  function automatic logic [63:0] lane_mask(logic [1:0] sz, int unsigned data_w,
                                            int unsigned lanes);
    return (64'd1 << lane_width(sz, data_w, lanes)) - 64'd1;
  endfunction

endpackage

// File: rtl/srot_step.sv
module srot_step
  import srot_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_LANES = 3
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        size_i,
  input  srot_op_e          op_i,
  input  logic              c_i,
  output logic [DATA_W-1:0] data_o,
  output logic              c_o,
  output logic              v_o
);
  localparam int unsigned SEL_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

  logic [NUM_LANES-1:0][DATA_W-1:0] lane_d;
  logic [NUM_LANES-1:0]             lane_c;
  logic [NUM_LANES-1:0]             lane_v;
  logic [SEL_W-1:0]                 sel;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int unsigned LW = DATA_W >> (NUM_LANES - 1 - g);
    logic [LW-1:0] x, r;
    logic          co, vo, top, bot;

    always_comb begin
      x   = data_i[LW-1:0];
      top = x[LW-1];
      bot = x[0];
      r   = x;
      co  = 1'b0;
      vo  = 1'b0;
      unique case (op_i)
        OP_SHLL:  begin r = {x[LW-2:0], 1'b0}; co = top; end
        OP_SHLR:  begin r = {1'b0, x[LW-1:1]}; co = bot; end
        OP_SHAL:  begin r = {x[LW-2:0], 1'b0}; co = top; vo = top ^ x[LW-2]; end
        OP_SHAR:  begin r = {top, x[LW-1:1]};  co = bot; end
        OP_ROTL:  begin r = {x[LW-2:0], top};  co = top; end
        OP_ROTR:  begin r = {bot, x[LW-1:1]};  co = bot; end
        OP_ROTXL: begin r = {x[LW-2:0], c_i};  co = top; end
        OP_ROTXR: begin r = {c_i, x[LW-1:1]};  co = bot; end
        default:  begin r = x; end
      endcase
    end

    assign lane_d[g] = DATA_W'(r);
    assign lane_c[g] = co;
    assign lane_v[g] = vo;
  end

  assign sel    = SEL_W'(lane_sel(size_i, NUM_LANES));
  assign data_o = lane_d[sel];
  assign c_o    = lane_c[sel];
  assign v_o    = lane_v[sel];

endmodule

// File: rtl/srot_wb.sv
module srot_wb
  import srot_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_LANES = 3
) (
  input  logic [DATA_W-1:0] orig_i,
  input  logic [DATA_W-1:0] shifted_i,
  input  logic [1:0]        size_i,
  output logic [DATA_W-1:0] wb_o,
  output logic              n_o,
  output logic              z_o
);
  logic [DATA_W-1:0] mask;
  int unsigned       msb_idx;

  always_comb begin
    mask    = DATA_W'(lane_mask(size_i, DATA_W, NUM_LANES));
    msb_idx = lane_width(size_i, DATA_W, NUM_LANES) - 1;
    wb_o    = (orig_i & ~mask) | (shifted_i & mask);
    n_o     = shifted_i[msb_idx];
    z_o     = ~|(shifted_i & mask);
  end

endmodule

// File: rtl/srot_unit.sv
module srot_unit
  import srot_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_LANES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [1:0]        size_i,
  input  logic [2:0]        op_i,
  input  logic              two_i,
  input  logic              carry_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              flag_n_o,
  output logic              flag_z_o,
  output logic              flag_v_o,
  output logic              flag_c_o
);
  localparam int unsigned N_STEPS = 2;

  srot_op_e                      op;
  logic [N_STEPS:0][DATA_W-1:0]  st_d;
  logic [N_STEPS:0]              st_c;
  logic [N_STEPS-1:0]            st_v;
  logic [DATA_W-1:0]             sh_d, wb_d;
  logic                          sh_c, sh_v, wb_n, wb_z;

  assign op      = srot_op_e'(op_i);
  assign st_d[0] = operand_i;
  assign st_c[0] = carry_i;

  // Each step consumes the previous step's value and carry.
  for (genvar s = 0; s < N_STEPS; s++) begin : g_step
    srot_step #(.DATA_W(DATA_W), .NUM_LANES(NUM_LANES)) i_step (
      .data_i (st_d[s]),
      .size_i (size_i),
      .op_i   (op),
      .c_i    (st_c[s]),
      .data_o (st_d[s+1]),
      .c_o    (st_c[s+1]),
      .v_o    (st_v[s])
    );
  end

  always_comb begin
    sh_d = two_i ? st_d[2] : st_d[1];
    sh_c = two_i ? st_c[2] : st_c[1];
    sh_v = two_i ? |st_v : st_v[0];
  end

  srot_wb #(.DATA_W(DATA_W), .NUM_LANES(NUM_LANES)) i_wb (
    .orig_i    (operand_i),
    .shifted_i (sh_d),
    .size_i    (size_i),
    .wb_o      (wb_d),
    .n_o       (wb_n),
    .z_o       (wb_z)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      flag_n_o <= 1'b0;
      flag_z_o <= 1'b0;
      flag_v_o <= 1'b0;
      flag_c_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= wb_d;
        flag_n_o <= wb_n;
        flag_z_o <= wb_z;
        flag_v_o <= sh_v;
        flag_c_o <= sh_c;
      end
    end
  end

  // Checks on the registered outputs against the sampled request.
  logic [DATA_W-1:0] act_mask;
  logic              in_msb;
  assign act_mask = DATA_W'(lane_mask(size_i, DATA_W, NUM_LANES));
  assign in_msb   = operand_i[lane_width(size_i, DATA_W, NUM_LANES) - 1];

  AST_VALID_PIPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o) && $stable(flag_c_o))); // R9
  AST_UPPER_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ((result_o ^ $past(operand_i)) & ~$past(act_mask)) == '0); // R1
  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (flag_z_o == ((result_o & $past(act_mask)) == '0))); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i != OP_SHAL) |=> !flag_v_o); // R3
  AST_SIGN_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_SHAR) |=> (flag_n_o == $past(in_msb))); // R5
  AST_ROT_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == OP_ROTL || op_i == OP_ROTR)) |=>
    ($countones(result_o & $past(act_mask)) ==
     $countones($past(operand_i) & $past(act_mask)))); // R6
  AST_ROTX_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == OP_ROTXL || op_i == OP_ROTXR)) |=>
    ($countones(result_o & $past(act_mask)) + int'(flag_c_o) ==
     $countones($past(operand_i) & $past(act_mask)) + int'($past(carry_i)))); // R7

endmodule

// File: tb/test_srot_unit.sv
module test_srot_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] operand_i = '0;
  logic [1:0]  size_i = '0;
  logic [2:0]  op_i = '0;
  logic        two_i = 1'b0;
  logic        carry_i = 1'b0;
  logic        valid_o;
  logic [31:0] result_o;
  logic        flag_n_o, flag_z_o, flag_v_o, flag_c_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [31:0] rng = 32'h1bad5eed;

  always #(CLK_PERIOD/2) clk = ~clk;

  srot_unit i_srot_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .operand_i(operand_i),
    .size_i(size_i), .op_i(op_i), .two_i(two_i), .carry_i(carry_i),
    .valid_o(valid_o), .result_o(result_o), .flag_n_o(flag_n_o),
    .flag_z_o(flag_z_o), .flag_v_o(flag_v_o), .flag_c_o(flag_c_o)
  );

  function automatic string op_tag(int op);
    case (op)
      0, 1:    return "R3";
      2:       return "R4";
      3:       return "R5";
      4, 5:    return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic ref_model(input logic [31:0] opnd, input int sz, input int op,
                           input bit two, input bit cin, output logic [31:0] res,
                           output bit n, output bit z, output bit v, output bit c);
    int          w;
    logic [31:0] m, val;
    bit          cc, top, bot, fill;
    w   = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    m   = (w == 32) ? 32'hffff_ffff : ((32'd1 << w) - 32'd1);
    val = opnd & m;
    cc  = cin;
    v   = 1'b0;
    for (int k = 0; k < (two ? 2 : 1); k++) begin
      top = val[w-1];
      bot = val[0];
      case (op)
        3:       fill = top;
        4:       fill = top;
        5:       fill = bot;
        6, 7:    fill = cc;
        default: fill = 1'b0;
      endcase
      if (op == 2 && (val[w-1] != val[w-2])) v = 1'b1;
      if (op % 2 == 0) begin
        val = ((val << 1) | 32'(fill)) & m;
        cc  = top;
      end else begin
        val = (val >> 1) | (32'(fill) << (w - 1));
        cc  = bot;
      end
    end
    n   = val[w-1];
    z   = (val == 32'd0);
    c   = cc;
    res = (opnd & ~m) | val;
  endtask

  task automatic run_op(input logic [31:0] opnd, input int sz, input int op,
                        input bit two, input bit cin);
    logic [31:0] e_res;
    bit e_n, e_z, e_v, e_c;
    ref_model(opnd, sz, op, two, cin, e_res, e_n, e_z, e_v, e_c);
    @(negedge clk);
    valid_i = 1'b1; operand_i = opnd; size_i = 2'(sz); op_i = 3'(op);
    two_i = two; carry_i = cin;
    @(negedge clk);
    valid_i = 1'b0;
    n_cmp++;
    if (valid_o !== 1'b1 || result_o !== e_res || flag_n_o !== e_n ||
        flag_z_o !== e_z || flag_v_o !== e_v || flag_c_o !== e_c) begin
      n_bad++;
      $display("FAIL %s (R1 R2 R8 R9) op=%0d sz=%0d two=%0d cin=%0d opnd=%h: got v%0d %h NZVC=%0d%0d%0d%0d exp v1 %h NZVC=%0d%0d%0d%0d",
               op_tag(op), op, sz, two, cin, opnd, valid_o, result_o, flag_n_o,
               flag_z_o, flag_v_o, flag_c_o, e_res, e_n, e_z, e_v, e_c);
    end
  endtask

  task automatic check_hold();
    logic [31:0] r0;
    logic [3:0]  f0;
    @(negedge clk);
    r0 = result_o;
    f0 = {flag_n_o, flag_z_o, flag_v_o, flag_c_o};
    valid_i = 1'b0; operand_i = ~operand_i; op_i = op_i + 3'd1; carry_i = ~carry_i;
    @(negedge clk);
    n_cmp++;
    if (valid_o !== 1'b0 || result_o !== r0 ||
        {flag_n_o, flag_z_o, flag_v_o, flag_c_o} !== f0) begin
      n_bad++;
      $display("FAIL R9 idle hold: got v%0d %h flags %b exp v0 %h flags %b",
               valid_o, result_o, {flag_n_o, flag_z_o, flag_v_o, flag_c_o}, r0, f0);
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired: got running exp finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] pats [14];
    pats = '{32'h0000_0080, 32'h0000_0040, 32'h0000_00c0, 32'h0000_8000,
             32'h0000_4000, 32'h8000_0000, 32'h4000_0000, 32'ha5a5_a5a5,
             32'h0000_0001, 32'h0000_0000, 32'hffff_ffff, 32'h1234_5681,
             32'h5a5a_8040, 32'hc000_c0c0};
    repeat (3) @(negedge clk);
    n_cmp++;
    if (valid_o !== 1'b0 || result_o !== 32'd0 ||
        {flag_n_o, flag_z_o, flag_v_o, flag_c_o} !== 4'b0) begin
      n_bad++;
      $display("FAIL R9 reset state: got v%0d %h flags %b exp v0 0 flags 0000",
               valid_o, result_o, {flag_n_o, flag_z_o, flag_v_o, flag_c_o});
    end
    rst_n = 1'b1;
    // R1 R2 R3 R4 R5 R6 R7 R8: full sweep of sizes, ops, amounts and carry
    foreach (pats[p])
      for (int sz = 0; sz < 4; sz++)
        for (int op = 0; op < 8; op++)
          for (int t = 0; t < 2; t++)
            for (int ci = 0; ci < 2; ci++)
              run_op(pats[p], sz, op, bit'(t), bit'(ci));
    check_hold();
    for (int i = 0; i < 400; i++) begin
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      run_op(rng, int'(rng[3:2]), int'(rng[7:5]), rng[9], rng[11]);
      if (i % 50 == 0) check_hold();
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule